// File: doc/BRIEF.md
# PWM Fault Protection Unit

This block sits between a PWM waveform generator and the output pins. It watches a set of external fault inputs and, when a fault that a channel cares about becomes active, replaces that channel's high-side and low-side drive with programmed safe levels. At the same moment it asks the channel's counter to restart. While no enabled fault is active on a channel, the drive coming from the output-override stage passes through unchanged.

Each fault input is configured separately. A polarity bit picks which input level counts as a fault. A filter bit either routes the input through a synchronizer and stability check or uses it directly. A mode bit makes the fault either follow the input or stay latched until software clears it. Each channel has its own fault mask. A channel marked synchronous uses channel 0's mask instead of its own. Software configures the unit through a simple write port, and it reads configuration and status back through a combinational read port.

Top module: `pwm_fault_guard`

## Requirements
- R1: Fault f is at its fault level when `fault_in[f]` equals bit f of the polarity register (address 0). A polarity bit of 1 means the fault level is high, and 0 means it is low.
- R2: When bit f of the filter register (address 1) is 1, the input passes through a two-flop synchronizer, and the filtered level only takes a value that two consecutive synchronized samples agree on. A fault level seen at a single rising edge never activates the fault. A level held steady reaches the outputs after the fourth rising edge.
- R3: When the filter bit is 0, the fault-level input reaches the channel outputs through combinational logic only. This holds even while `clk` is stopped.
- R4: When bit f of the mode register (address 2) is 0, the fault is active exactly while its (filtered or unfiltered) level is the fault level.
- R5: When the mode bit is 1, the fault stays active after its level goes away. It becomes inactive at the rising edge where a 1 is written to bit f of the clear register (address 3) while the level is not the fault level. A clear written while the level is still the fault level has no effect.
- R6: Channel c uses the mask at address 8+c, where bit f enables fault f. When `chan_sync[c]` is 1, the channel uses the mask of channel 0 instead.
- R7: A channel whose `chan_en` bit is 0 is never forced, and its outputs equal `ovr_h`/`ovr_l`.
- R8: A channel that is enabled and has at least one active fault in its effective mask drives `pwm_h[c]` = bit c of address 5 and `pwm_l[c]` = bit c of address 6. Forcing takes priority over `ovr_h`/`ovr_l`, which pass through otherwise.
- R9: `cnt_rst[c]` is high for exactly one cycle. That cycle starts at the rising edge that follows the cycle in which channel c entered the forced state.
- R10: Reading address 4 returns the active state of each fault in bits [NUM_FAULTS-1:0] and the raw `fault_in` pins in bits [16+NUM_FAULTS-1:16]. All other bits read 0.
- R11: Addresses 0, 1, 2, 5, 6 and 8+c store the full 16-bit `wr_data` on a write and read it back in `rd_data[15:0]`. Address 3 and unmapped addresses read 0. After reset, every register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_in | input | NUM_FAULTS | Raw fault inputs |
| chan_en | input | NUM_CH | Channel enable flags |
| chan_sync | input | NUM_CH | Channel uses channel 0's fault mask |
| ovr_h | input | NUM_CH | High-side drive from the override stage |
| ovr_l | input | NUM_CH | Low-side drive from the override stage |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| pwm_h | output | NUM_CH | Final high-side outputs |
| pwm_l | output | NUM_CH | Final low-side outputs |
| cnt_rst | output | NUM_CH | Single-cycle counter restart request per channel |

## Verification
The results arrive with different delays:
- Unfiltered faults, enable changes, mask changes and override changes reach `pwm_h`/`pwm_l` in the same cycle.
- Filtered faults reach them after the fourth rising edge.
- A clear acts at the edge that samples the write.
- `cnt_rst` follows one edge after entry into the forced state.

The bench drives inputs shortly after each falling edge. A behavioural model advances on each rising edge, and its outputs are compared with the design's at the following falling edge, so each result is checked in the cycle it is due. The directed checks count falling edges to match these delays. The clockless case is checked a few time units after the input changes, while the clock is held low.

// File: rtl/pwm_fault_pkg.sv
package pwm_fault_pkg;
   localparam int            REG_W     = 16;
   localparam int            ADDR_W    = 4;
   localparam int            RD_W      = 32;
   localparam int            RAW_LSB   = 16;
   localparam logic [3:0]    A_POL     = 4'd0;
   localparam logic [3:0]    A_FILT    = 4'd1;
   localparam logic [3:0]    A_MODE    = 4'd2;
   localparam logic [3:0]    A_CLR     = 4'd3;
   localparam logic [3:0]    A_STAT    = 4'd4;
   localparam logic [3:0]    A_SAFE_H  = 4'd5;
   localparam logic [3:0]    A_SAFE_L  = 4'd6;
   localparam logic [3:0]    A_MASK0   = 4'd8;
endpackage

// File: rtl/pfg_fault_cond.sv
module pfg_fault_cond #(
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_FILTER  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fault_pin,
   input  logic pol,
   input  logic filt_en,
   input  logic latch_mode,
   input  logic clr_req,
   output logic active
);
   logic lvl;
   logic cond;
   logic lat_q;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   assign lvl = (fault_pin == pol);

   if (HAS_FILTER) begin : g_filt
      logic [SYNC_STAGES:0] chain;
      logic                 flt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= '0;
            flt_q <= 1'b0;
         end else begin
            chain <= {chain[SYNC_STAGES-1:0], lvl};
            if (chain[SYNC_STAGES] == chain[SYNC_STAGES-1])
               flt_q <= chain[SYNC_STAGES-1];
         end
      end

      assign cond = filt_en ? flt_q : lvl;

      // R2
      flt_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (flt_q != $past(flt_q)) |-> ($past(chain[SYNC_STAGES]) == $past(chain[SYNC_STAGES-1])));
   end else begin : g_nofilt
      assign cond = lvl;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           lat_q <= 1'b0;
      else if (!latch_mode) lat_q <= 1'b0;
      else if (cond)        lat_q <= 1'b1;
      else if (clr_req)     lat_q <= 1'b0;
   end

   assign active = cond | lat_q;

   // R5
   lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_q && latch_mode && !clr_req) |=> lat_q);

   // R5
   clr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_mode && cond && clr_req) |=> lat_q);
endmodule

// File: rtl/pfg_chan_force.sv
module pfg_chan_force #(
   parameter int NF = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          chan_on,
   input  logic [NF-1:0] fault_mask,
   input  logic [NF-1:0] fault_act,
   input  logic          safe_h,
   input  logic          safe_l,
   input  logic          ovr_h,
   input  logic          ovr_l,
   output logic          out_h,
   output logic          out_l,
   output logic          cnt_rst
);
   logic trig;
   logic trig_q;

   assign trig  = chan_on & (|(fault_mask & fault_act));
   assign out_h = trig ? safe_h : ovr_h;
   assign out_l = trig ? safe_l : ovr_l;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_q  <= 1'b0;
         cnt_rst <= 1'b0;
      end else begin
         trig_q  <= trig;
         cnt_rst <= trig & ~trig_q;
      end
   end

   // R9
   cnt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_rst |=> !cnt_rst);

   // R9
   cnt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_rst |-> $past(trig));

   // R7
   off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_on |-> (out_h == ovr_h && out_l == ovr_l));
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
   import pwm_fault_pkg::*;
#(
   parameter int NUM_FAULTS     = 6,
   parameter int NUM_CH         = 4,
   parameter int SYNC_STAGES    = 2,
   parameter bit FILTER_PRESENT = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_FAULTS-1:0] fault_in,
   input  logic [NUM_CH-1:0]     chan_en,
   input  logic [NUM_CH-1:0]     chan_sync,
   input  logic [NUM_CH-1:0]     ovr_h,
   input  logic [NUM_CH-1:0]     ovr_l,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [REG_W-1:0]      wr_data,
   input  logic [ADDR_W-1:0]     rd_addr,
   output logic [RD_W-1:0]       rd_data,
   output logic [NUM_CH-1:0]     pwm_h,
   output logic [NUM_CH-1:0]     pwm_l,
   output logic [NUM_CH-1:0]     cnt_rst
);
   localparam int NF = NUM_FAULTS;

   if (NUM_FAULTS < 1 || NUM_FAULTS > REG_W) begin : g_bad_nf
      $error("NUM_FAULTS must be between 1 and 16");
   end
   if (NUM_CH < 1 || NUM_CH > 8) begin : g_bad_nch
      $error("NUM_CH must be between 1 and 8");
   end

   logic [REG_W-1:0] pol_q, filt_q, mode_q, safe_h_q, safe_l_q;
   logic [REG_W-1:0] mask_q [NUM_CH];
   logic [NF-1:0]    clr_vec;
   logic [NF-1:0]    active;

   assign clr_vec = (wr_en && wr_addr == A_CLR) ? wr_data[NF-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_q    <= '0;
         filt_q   <= '0;
         mode_q   <= '0;
         safe_h_q <= '0;
         safe_l_q <= '0;
         for (int c = 0; c < NUM_CH; c++) mask_q[c] <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            A_POL:    pol_q    <= wr_data;
            A_FILT:   filt_q   <= wr_data;
            A_MODE:   mode_q   <= wr_data;
            A_SAFE_H: safe_h_q <= wr_data;
            A_SAFE_L: safe_l_q <= wr_data;
            default: ;
         endcase
         for (int c = 0; c < NUM_CH; c++)
            if (wr_addr == 4'(A_MASK0 + c)) mask_q[c] <= wr_data;
      end
   end

   for (genvar f = 0; f < NF; f++) begin : g_fault
      pfg_fault_cond #(
         .SYNC_STAGES (SYNC_STAGES),
         .HAS_FILTER  (FILTER_PRESENT)
      ) u_cond (
         .clk        (clk),
         .rst_n      (rst_n),
         .fault_pin  (fault_in[f]),
         .pol        (pol_q[f]),
         .filt_en    (filt_q[f]),
         .latch_mode (mode_q[f]),
         .clr_req    (clr_vec[f]),
         .active     (active[f])
      );
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      logic [NF-1:0] eff_mask;
      assign eff_mask = chan_sync[c] ? mask_q[0][NF-1:0] : mask_q[c][NF-1:0];

      pfg_chan_force #(.NF(NF)) u_force (
         .clk        (clk),
         .rst_n      (rst_n),
         .chan_on    (chan_en[c]),
         .fault_mask (eff_mask),
         .fault_act  (active),
         .safe_h     (safe_h_q[c]),
         .safe_l     (safe_l_q[c]),
         .ovr_h      (ovr_h[c]),
         .ovr_l      (ovr_l[c]),
         .out_h      (pwm_h[c]),
         .out_l      (pwm_l[c]),
         .cnt_rst    (cnt_rst[c])
      );
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         A_POL:    rd_data[REG_W-1:0] = pol_q;
         A_FILT:   rd_data[REG_W-1:0] = filt_q;
         A_MODE:   rd_data[REG_W-1:0] = mode_q;
         A_SAFE_H: rd_data[REG_W-1:0] = safe_h_q;
         A_SAFE_L: rd_data[REG_W-1:0] = safe_l_q;
         A_STAT: begin
            rd_data[NF-1:0]         = active;
            rd_data[RAW_LSB +: NF]  = fault_in;
         end
         default: ;
      endcase
      for (int c = 0; c < NUM_CH; c++)
         if (rd_addr == 4'(A_MASK0 + c)) rd_data[REG_W-1:0] = mask_q[c];
   end

   // R11
   clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == A_CLR) |-> (rd_data == '0));
endmodule

// File: tb/pwm_fault_guard_test.sv
module pwm_fault_guard_test;
   localparam int NF  = 6;
   localparam int NCH = 4;

   logic            clk = 1'b0;
   bit              clk_run = 1'b1;
   logic            rst_n = 1'b0;
   logic [NF-1:0]   fault_in = '0;
   logic [NCH-1:0]  chan_en = '0, chan_sync = '0, ovr_h = '0, ovr_l = '0;
   logic            wr_en = 1'b0;
   logic [3:0]      wr_addr = '0, rd_addr = '0;
   logic [15:0]     wr_data = '0;
   logic [31:0]     rd_data;
   logic [NCH-1:0]  pwm_h, pwm_l, cnt_rst;

   int    vectors = 0;
   int    miscmp  = 0;
   string cur_req = "R11";

   pwm_fault_guard uut (
      .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .chan_en(chan_en),
      .chan_sync(chan_sync), .ovr_h(ovr_h), .ovr_l(ovr_l), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .pwm_h(pwm_h), .pwm_l(pwm_l), .cnt_rst(cnt_rst)
   );

   always begin
      #10;
      if (clk_run) clk = ~clk;
   end

   // ---------------- reference model ----------------
   logic [15:0]    r_pol = '0, r_filt = '0, r_mode = '0, r_sh = '0, r_sl = '0;
   logic [15:0]    r_mask [NCH] = '{default: '0};
   logic [NF-1:0]  m_s1 = '0, m_s2 = '0, m_s3 = '0, m_flt = '0, m_lat = '0;
   logic [NCH-1:0] m_trq = '0, m_rst = '0;

   function automatic logic [NF-1:0] m_cond();
      logic [NF-1:0] lv;
      lv = ~(fault_in ^ r_pol[NF-1:0]);
      return (r_filt[NF-1:0] & m_flt) | (~r_filt[NF-1:0] & lv);
   endfunction

   function automatic logic [NF-1:0] m_active();
      return m_cond() | m_lat;
   endfunction

   function automatic logic [NCH-1:0] m_trig();
      logic [NCH-1:0] t;
      for (int c = 0; c < NCH; c++) begin
         logic [15:0] mk;
         mk = chan_sync[c] ? r_mask[0] : r_mask[c];
         t[c] = chan_en[c] && ((mk[NF-1:0] & m_active()) != '0);
      end
      return t;
   endfunction

   function automatic logic [31:0] m_rd();
      logic [31:0] v;
      v = '0;
      case (rd_addr)
         4'd0: v[15:0] = r_pol;
         4'd1: v[15:0] = r_filt;
         4'd2: v[15:0] = r_mode;
         4'd4: begin v[NF-1:0] = m_active(); v[16 +: NF] = fault_in; end
         4'd5: v[15:0] = r_sh;
         4'd6: v[15:0] = r_sl;
         4'd8, 4'd9, 4'd10, 4'd11: v[15:0] = r_mask[rd_addr - 4'd8];
         default: ;
      endcase
      return v;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         r_pol = '0; r_filt = '0; r_mode = '0; r_sh = '0; r_sl = '0;
         for (int c = 0; c < NCH; c++) r_mask[c] = '0;
         m_s1 = '0; m_s2 = '0; m_s3 = '0; m_flt = '0; m_lat = '0;
         m_trq = '0; m_rst = '0;
      end else begin
         logic [NF-1:0]  cnd, clr, lv;
         logic [NCH-1:0] tg;
         cnd = m_cond();
         tg  = m_trig();
         lv  = ~(fault_in ^ r_pol[NF-1:0]);
         clr = (wr_en && wr_addr == 4'd3) ? wr_data[NF-1:0] : '0;
         for (int f = 0; f < NF; f++) begin
            if (!r_mode[f])   m_lat[f] = 1'b0;
            else if (cnd[f])  m_lat[f] = 1'b1;
            else if (clr[f])  m_lat[f] = 1'b0;
            if (m_s2[f] == m_s3[f]) m_flt[f] = m_s2[f];
         end
         m_s3  = m_s2;
         m_s2  = m_s1;
         m_s1  = lv;
         m_rst = tg & ~m_trq;
         m_trq = tg;
         if (wr_en) begin
            case (wr_addr)
               4'd0: r_pol  = wr_data;
               4'd1: r_filt = wr_data;
               4'd2: r_mode = wr_data;
               4'd5: r_sh   = wr_data;
               4'd6: r_sl   = wr_data;
               4'd8, 4'd9, 4'd10, 4'd11: r_mask[wr_addr - 4'd8] = wr_data;
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscmp++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      logic [NCH-1:0] t, eh, el;
      t  = m_trig();
      eh = (t & r_sh[NCH-1:0]) | (~t & ovr_h);
      el = (t & r_sl[NCH-1:0]) | (~t & ovr_l);
      chk(cur_req, "pwm_h (R8)", 32'(pwm_h), 32'(eh));
      chk(cur_req, "pwm_l (R8)", 32'(pwm_l), 32'(el));
      chk(cur_req, "cnt_rst (R9)", 32'(cnt_rst), 32'(m_rst));
      chk(cur_req, "rd_data (R10)", rd_data, m_rd());
   end

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk); #2;
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); #2;
      wr_en = 1'b0;
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
      #2;
   endtask

   initial begin
      #(200000 * 20);
      miscmp++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
   end

   initial begin
      ovr_h = 4'b1010; ovr_l = 4'b0101; fault_in = 6'b000100;
      step(3);
      // R11 reset state
      chk("R11", "reset pwm_h", 32'(pwm_h), 32'(4'b1010));
      chk("R11", "reset pwm_l", 32'(pwm_l), 32'(4'b0101));
      chk("R11", "reset cnt_rst", 32'(cnt_rst), 32'd0);
      rst_n = 1'b1;

      // R11 configuration and readback
      wr(4'd0, 16'hA03B);
      wr(4'd1, 16'h0007);
      wr(4'd2, 16'h0012);
      wr(4'd5, 16'h0005);
      wr(4'd6, 16'h000A);
      wr(4'd8, 16'h0003);
      wr(4'd9, 16'h0010);
      wr(4'd10, 16'h0028);
      wr(4'd11, 16'h0004);
      rd_addr = 4'd0; #1 chk("R11", "pol readback", rd_data, 32'h0000A03B);
      rd_addr = 4'd2; #1 chk("R11", "mode readback", rd_data, 32'h00000012);
      rd_addr = 4'd10; #1 chk("R11", "mask2 readback", rd_data, 32'h00000028);
      rd_addr = 4'd3; #1 chk("R11", "clear reads zero", rd_data, 32'h0);
      rd_addr = 4'd4;
      chan_en = 4'b1111;
      step(6);

      // R2 single-edge pulse on filtered fault 0 is rejected
      cur_req = "R2";
      fault_in[0] = 1'b1;
      step(1);
      fault_in[0] = 1'b0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         chk("R2", "pulse rejected pwm_h[0]", 32'(pwm_h[0]), 32'(1'b0));
      end
      #2 fault_in[0] = 1'b1;
      repeat (3) @(negedge clk);
      chk("R2", "not yet forced at edge 3", 32'(pwm_h[0]), 32'(1'b0));
      @(negedge clk);
      chk("R2", "forced at edge 4", 32'(pwm_h[0]), 32'(1'b1));
      chk("R2", "forced low side", 32'(pwm_l[0]), 32'(1'b0));
      chk("R9", "no pulse yet", 32'(cnt_rst[0]), 32'(1'b0));
      @(negedge clk);
      chk("R9", "restart pulse", 32'(cnt_rst[0]), 32'(1'b1));
      @(negedge clk);
      chk("R9", "pulse one cycle", 32'(cnt_rst[0]), 32'(1'b0));
      #2;

      // R6 synchronous channel 3 takes channel 0 mask
      cur_req = "R6";
      chk("R6", "ch3 own mask idle", 32'(pwm_h[3]), 32'(1'b1));
      chan_sync[3] = 1'b1; #1;
      chk("R6", "ch3 uses ch0 mask", 32'(pwm_h[3]), 32'(1'b0));
      step(2);

      // R7 disabled channel never forced
      cur_req = "R7";
      chan_en[0] = 1'b0; #1;
      chk("R7", "ch0 disabled passes override", 32'(pwm_h[0]), 32'(1'b0));
      chk("R7", "ch3 still forced", 32'(pwm_h[3]), 32'(1'b0));
      step(2);
      chan_en[0] = 1'b1; chan_sync[3] = 1'b0;
      fault_in[0] = 1'b0;
      step(6);

      // R1 fault 2 has low polarity
      cur_req = "R1";
      fault_in[2] = 1'b0;
      step(5);
      chk("R1", "low level forces ch3", 32'(pwm_l[3]), 32'(1'b1));
      fault_in[2] = 1'b1;
      step(5);
      chk("R1", "high level releases ch3", 32'(pwm_l[3]), 32'(1'b0));

      // R5 latched unfiltered fault 4 on channel 1
      cur_req = "R5";
      fault_in[4] = 1'b1; #1;
      chk("R5", "latched fault forces ch1", 32'(pwm_h[1]), 32'(1'b0));
      wr(4'd3, 16'h0010);
      fault_in[4] = 1'b0;
      step(2);
      chk("R5", "clear at fault level ignored", 32'(pwm_h[1]), 32'(1'b0));
      wr(4'd3, 16'h0010);
      @(negedge clk);
      chk("R5", "clear releases ch1", 32'(pwm_h[1]), 32'(1'b1));
      #2;

      // R4 level mode, unfiltered fault 5 on channel 2
      cur_req = "R4";
      fault_in[5] = 1'b1; #1;
      chk("R4", "level fault forces ch2", 32'(pwm_h[2]), 32'(1'b1));
      step(2);
      fault_in[5] = 1'b0; #1;
      chk("R4", "level fault follows input", 32'(pwm_h[2]), 32'(1'b0));
      chk("R10", "raw level readback", 32'(rd_data[16 +: NF]), 32'(fault_in));
      step(2);

      // R3 unfiltered fault 3 acts with clock stopped
      cur_req = "R3";
      @(negedge clk);
      clk_run = 1'b0;
      #50 fault_in[3] = 1'b1; #1;
      chk("R3", "clockless force pwm_h[2]", 32'(pwm_h[2]), 32'(1'b1));
      chk("R3", "clockless force pwm_l[2]", 32'(pwm_l[2]), 32'(1'b0));
      fault_in[3] = 1'b0; #1;
      chk("R3", "clockless release pwm_h[2]", 32'(pwm_h[2]), 32'(1'b0));
      #38 clk_run = 1'b1;
      step(4);

      // R8 random traffic against the model
      cur_req = "R8";
      for (int i = 0; i < 3000; i++) begin
         for (int f = 0; f < NF; f++)
            if ($urandom_range(0, 5) == 0) fault_in[f] = ~fault_in[f];
         if ($urandom_range(0, 6) == 0) begin
            ovr_h = 4'($urandom); ovr_l = 4'($urandom);
         end
         if ($urandom_range(0, 40) == 0) chan_en[$urandom_range(0, 3)] ^= 1'b1;
         if ($urandom_range(0, 60) == 0) chan_sync = 4'($urandom);
         rd_addr = 4'($urandom_range(0, 11));
         wr_en = 1'b0;
         if ($urandom_range(0, 9) == 0) begin
            wr_en = 1'b1; wr_addr = 4'd3; wr_data = 16'($urandom);
         end else if ($urandom_range(0, 150) == 0) begin
            wr_en = 1'b1; wr_addr = 4'($urandom_range(0, 11)); wr_data = 16'($urandom);
         end
         step(1);
      end
      wr_en = 1'b0;
      step(2);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
   end
endmodule